// File: doc/BRIEF.md
# Synchronous Burst Address Sequencer

This block produces the array address for a synchronous burst memory. At a rising clock edge where either of two active-low address strobes is asserted (one driven by a processor, one by a cache controller), it captures a 16-bit start address together with a small vector of chip-select levels. It then steps through a four-beat burst under control of an active-low advance input. Only the two low address bits take part in the burst. The upper bits keep the value captured at the load for the whole burst.

A level input picks the beat order. When it is high, the low bits are the start bits XOR the beat count (interleaved). When it is low, they are the start bits plus the beat count, modulo four (linear). If the advance input is high and no strobe is active, the burst is suspended and the same location is presented again. After the fourth beat the burst wraps back to its start address. When both strobes are active together, the processor strobe wins, and the load is marked as a read start.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the registered start address, beat count, captured selects and read-start flag all clear to zero, so `mem_addr`, `beat`, `sel_q` and `rd_start` read 0 afterwards.
- R2: At an edge where `strobe_proc_n` or `strobe_ctrl_n` is low, `addr_in` is captured. After that edge `beat` is 0 and `mem_addr` equals the captured address.
- R3: `rd_start` holds the source of the most recent load. It is 1 if `strobe_proc_n` was low at that load, including when both strobes were low, and 0 if only `strobe_ctrl_n` was low.
- R4: At an edge with both strobes high and `advance_n` low, `beat` increments by one modulo 4.
- R5: At an edge with both strobes high and `advance_n` high, `beat` and `mem_addr` keep their values (the burst is suspended).
- R6: With `order_sel` = 0 (linear), `mem_addr[1:0]` equals (start[1:0] + `beat`) mod 4.
- R7: With `order_sel` = 1 (interleaved), `mem_addr[1:0]` equals start[1:0] XOR `beat`.
- R8: `mem_addr[15:2]` does not change between loads.
- R9: Four advances after a load bring `beat` back to 0 and `mem_addr` back to the start address.
- R10: `sel_in` is sampled only at a load. At all other edges `sel_q` holds its value, whatever `sel_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | 16 | External start address |
| strobe_proc_n | input | 1 | Processor address strobe, active low, has priority |
| strobe_ctrl_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Advance to next beat, active low; high suspends |
| order_sel | input | 1 | 1 = interleaved (XOR) order, 0 = linear order |
| sel_in | input | 3 | Chip-select levels captured at a load |
| mem_addr | output | 16 | Current array address |
| beat | output | 2 | Burst position, 0 to 3 |
| sel_q | output | 3 | Chip-select levels held since the last load |
| rd_start | output | 1 | Last load came from the processor strobe |

## Verification
The hardest case to reach is a full wrap that has suspends mixed into it while `order_sel` toggles in the middle of the burst. The low address bits must then follow the new order at once, and the count of advances must still close the burst on its start address. Directed sequences set up each start offset under both orders and insert suspends between advances. A seeded random phase then loads rarely compared with how often it advances, suspends and flips the order, so that long bursts with changing order and stray `sel_in` values occur often.

// File: rtl/bseq_pkg.sv
// Package: shared operation type for the burst address sequencer.
// Assumes strobes and advance are already synchronous to clk.
package bseq_pkg;
    typedef enum logic [1:0] {
        OP_HOLD      = 2'd0,
        OP_STEP      = 2'd1,
        OP_LOAD_PROC = 2'd2,
        OP_LOAD_CTRL = 2'd3
    } bseq_op_e;
endpackage

// File: rtl/bseq_arbiter.sv
// Decodes the two strobes and the advance input into one operation.
// Processor strobe outranks controller strobe; any strobe outranks advance.
module bseq_arbiter
    import bseq_pkg::*;
(
    input  logic     strobe_proc_n,
    input  logic     strobe_ctrl_n,
    input  logic     advance_n,
    output bseq_op_e op
);
    // Priority decode of the control inputs.
    always_comb begin
        if (!strobe_proc_n)      op = OP_LOAD_PROC;
        else if (!strobe_ctrl_n) op = OP_LOAD_CTRL;
        else if (!advance_n)     op = OP_STEP;
        else                     op = OP_HOLD;
    end
endmodule

// File: rtl/bseq_capture.sv
// Start-address, select and load-source registers.
// Written only on a load; they keep their values otherwise.
module bseq_capture
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bseq_op_e          op,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [SEL_W-1:0]  sel_in,
    output logic [ADDR_W-1:0] base_q,
    output logic [SEL_W-1:0]  sel_q,
    output logic              rd_start_q
);
    logic is_load;
    assign is_load = (op == OP_LOAD_PROC) || (op == OP_LOAD_CTRL);

    // Capture address, selects and strobe source on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            sel_q      <= '0;
            rd_start_q <= 1'b0;
        end else if (is_load) begin
            base_q     <= addr_in;
            sel_q      <= sel_in;
            rd_start_q <= (op == OP_LOAD_PROC);
        end
    end
endmodule

// File: rtl/bseq_beat_ctr.sv
// Beat counter for the burst. A load clears it, a step adds one (wrapping
// naturally at 2**BURST_W) and a hold keeps it.
module bseq_beat_ctr
    import bseq_pkg::*;
#(
    parameter int BURST_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  bseq_op_e           op,
    output logic [BURST_W-1:0] beat_q
);
    // Count beats of the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            unique case (op)
                OP_LOAD_PROC, OP_LOAD_CTRL: beat_q <= '0;
                OP_STEP:                    beat_q <= beat_q + 1'b1;
                default:                    beat_q <= beat_q;
            endcase
        end
    end
endmodule

// File: rtl/bseq_order.sv
// Maps the start low bits and the beat count to the low address bits.
// Interleaved: start XOR beat, built bit by bit. Linear: start + beat mod 2**BURST_W.
module bseq_order #(
    parameter int BURST_W = 2
) (
    input  logic [BURST_W-1:0] start_low,
    input  logic [BURST_W-1:0] beat,
    input  logic               interleave,
    output logic [BURST_W-1:0] low_addr
);
    logic [BURST_W-1:0] xor_low;
    logic [BURST_W-1:0] lin_low;

    for (genvar i = 0; i < BURST_W; i++) begin : g_xor
        assign xor_low[i] = start_low[i] ^ beat[i];
    end

    assign lin_low = start_low + beat;

    // Pick the order requested by the mode input.
    always_comb begin
        low_addr = interleave ? xor_low : lin_low;
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Top of the burst address sequencer. Assumes all inputs except order_sel
// meet setup to clk; order_sel is a static level and acts combinationally.
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BURST_W = 2,
    parameter int SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic               strobe_proc_n,
    input  logic               strobe_ctrl_n,
    input  logic               advance_n,
    input  logic               order_sel,
    input  logic [SEL_W-1:0]   sel_in,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [BURST_W-1:0] beat,
    output logic [SEL_W-1:0]   sel_q,
    output logic               rd_start
);
    localparam int HI_W = ADDR_W - BURST_W;

    bseq_op_e           op;
    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] low_addr;

    bseq_arbiter u_arb (
        .strobe_proc_n (strobe_proc_n),
        .strobe_ctrl_n (strobe_ctrl_n),
        .advance_n     (advance_n),
        .op            (op)
    );

    bseq_capture #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .addr_in    (addr_in),
        .sel_in     (sel_in),
        .base_q     (base_q),
        .sel_q      (sel_q),
        .rd_start_q (rd_start)
    );

    bseq_beat_ctr #(.BURST_W(BURST_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .beat_q (beat)
    );

    bseq_order #(.BURST_W(BURST_W)) u_ord (
        .start_low  (base_q[BURST_W-1:0]),
        .beat       (beat),
        .interleave (order_sel),
        .low_addr   (low_addr)
    );

    // Upper bits come straight from the captured start; low bits from the order map.
    always_comb begin
        mem_addr = {base_q[ADDR_W-1 -: HI_W], low_addr};
    end
endmodule

// File: rtl/bseq_checker.sv
// Temporal checks on the sequencer ports, bound into every instance.
module bseq_checker #(
    parameter int ADDR_W  = 16,
    parameter int BURST_W = 2,
    parameter int SEL_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  addr_in,
    input logic               strobe_proc_n,
    input logic               strobe_ctrl_n,
    input logic               advance_n,
    input logic [SEL_W-1:0]   sel_in,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [BURST_W-1:0] beat,
    input logic [SEL_W-1:0]   sel_q,
    input logic               rd_start
);
    logic any_strobe;
    assign any_strobe = !strobe_proc_n || !strobe_ctrl_n;

    assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |=> (beat == '0) && (mem_addr == $past(addr_in)));

    assert_proc_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_proc_n |=> rd_start);

    assert_ctrl_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_proc_n && !strobe_ctrl_n) |=> !rd_start);

    assert_advance_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_strobe && !advance_n) |=> (beat == $past(beat) + 1'b1));

    assert_suspend_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_strobe && advance_n) |=> $stable(beat));

    assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !any_strobe |=> $stable(mem_addr[ADDR_W-1:BURST_W]));

    assert_sel_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |=> (sel_q == $past(sel_in)));

    assert_sel_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !any_strobe |=> $stable(sel_q) && $stable(rd_start));
endmodule

bind burst_addr_seq bseq_checker #(
    .ADDR_W(ADDR_W), .BURST_W(BURST_W), .SEL_W(SEL_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr_in       (addr_in),
    .strobe_proc_n (strobe_proc_n),
    .strobe_ctrl_n (strobe_ctrl_n),
    .advance_n     (advance_n),
    .sel_in        (sel_in),
    .mem_addr      (mem_addr),
    .beat          (beat),
    .sel_q         (sel_q),
    .rd_start      (rd_start)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] addr_in;
    logic        strobe_proc_n, strobe_ctrl_n, advance_n, order_sel;
    logic [2:0]  sel_in;
    logic [15:0] mem_addr;
    logic [1:0]  beat;
    logic [2:0]  sel_q;
    logic        rd_start;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;

    // Reference state, updated from the requirements.
    logic [15:0] m_base;
    logic [1:0]  m_beat;
    logic [2:0]  m_sel;
    logic        m_rd;

    always #2.5 clk = ~clk;

    burst_addr_seq dut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .strobe_proc_n(strobe_proc_n), .strobe_ctrl_n(strobe_ctrl_n),
        .advance_n(advance_n), .order_sel(order_sel), .sel_in(sel_in),
        .mem_addr(mem_addr), .beat(beat), .sel_q(sel_q), .rd_start(rd_start)
    );

    // Expected address: R6 linear sum, R7 interleaved XOR, upper bits fixed.
    function automatic logic [15:0] exp_addr(logic [15:0] b, logic [1:0] k, logic il);
        logic [1:0] lo;
        lo = il ? (b[1:0] ^ k) : 2'(b[1:0] + k);
        return {b[15:2], lo};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        check(tag, 32'(mem_addr), 32'(exp_addr(m_base, m_beat, order_sel)));
        check("R4 beat", 32'(beat), 32'(m_beat));
        check("R10 sel_q", 32'(sel_q), 32'(m_sel));
        check("R3 rd_start", 32'(rd_start), 32'(m_rd));
    endtask

    // Drive one cycle (called just after a falling edge), update model, check.
    task automatic step(logic [15:0] a, logic sp, logic sc, logic adv,
                        logic md, logic [2:0] s, string tag);
        addr_in = a; strobe_proc_n = sp; strobe_ctrl_n = sc;
        advance_n = adv; order_sel = md; sel_in = s;
        @(posedge clk);
        if (!rst_n) begin
            m_base = '0; m_beat = '0; m_sel = '0; m_rd = 1'b0;
        end else if (!sp || !sc) begin
            m_base = a; m_beat = '0; m_sel = s; m_rd = !sp;
        end else if (!adv) begin
            m_beat = m_beat + 2'd1;
        end
        #1;
        check_all(tag);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        rst_n = 1'b0;
        @(negedge clk);
        // R1: reset clears everything, even with a strobe active.
        step(16'hBEEF, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111, "R1 reset");
        step(16'h1234, 1'b1, 1'b1, 1'b0, 1'b1, 3'b101, "R1 reset");
        check("R1 mem_addr zero", 32'(mem_addr), 32'h0);
        rst_n = 1'b1;

        // R2/R6/R9: controller load, linear, start 2 -> 2,3,0,1, then wrap to 2.
        step(16'hA5A6, 1'b1, 1'b0, 1'b1, 1'b0, 3'b011, "R2 load ctrl");
        check("R2 mem_addr", 32'(mem_addr), 32'hA5A6);
        for (int i = 0; i < 4; i++) step(16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 3'b100, "R6 linear");
        check("R9 wrap", 32'(mem_addr), 32'hA5A6);

        // R3: both strobes -> processor wins; R7 interleaved start 1 -> 1,0,3,2.
        step(16'h7F01, 1'b0, 1'b0, 1'b1, 1'b1, 3'b110, "R3 both strobes");
        check("R3 proc wins", 32'(rd_start), 32'h1);
        for (int i = 0; i < 3; i++) step(16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b1, 3'b001, "R7 interleave");
        check("R7 last beat", 32'(mem_addr), 32'h7F02);

        // R5/R10/R8: suspend with changing address and selects.
        step(16'h0003, 1'b1, 1'b1, 1'b1, 1'b1, 3'b000, "R5 suspend");
        step(16'h8888, 1'b1, 1'b1, 1'b1, 1'b1, 3'b111, "R5 suspend");
        check("R10 sel held", 32'(sel_q), 32'h6);
        step(16'h4444, 1'b1, 1'b1, 1'b0, 1'b1, 3'b010, "R9 wrap interleave");
        check("R9 back to start", 32'(mem_addr), 32'h7F01);
        check("R8 upper fixed", 32'(mem_addr[15:2]), 32'(16'h7F01 >> 2));

        // Controller-only load after a processor load clears rd_start (R3).
        step(16'h0C03, 1'b1, 1'b0, 1'b0, 1'b0, 3'b101, "R3 ctrl load");

        // Random phase: loads rare, advance/suspend/order flips common.
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            logic sp, sc, adv, md;
            logic [2:0] s;
            int unsigned r;
            r   = $urandom % 16;
            a   = 16'($urandom);
            sp  = !(r == 0 || r == 1);
            sc  = !(r == 1 || r == 2);
            adv = ($urandom % 4) == 0;
            md  = ($urandom % 8) == 0 ? !order_sel : order_sel;
            s   = 3'($urandom);
            step(a, sp, sc, adv, md, s, md ? "R7 random" : "R6 random");
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule